// File: doc/BRIEF.md
# I2C Target Read-Path Engine with Clock Stretching

This block is the slave-transmit side of an I2C target. It watches open-drain SCL and SDA through a system clock that runs at least eight times faster than SCL. It recognises START, repeated START and STOP. It compares the received 7-bit address with its own address and, on a read, returns bytes that a host supplies through a one-entry transmit register. Behind that register sits an 8-bit shift register that drives SDA, MSB first.

The block never lets the bus run ahead of the host. After a matching read address, SCL is held low and the address ACK is withheld until the host writes the first byte. After each acknowledged byte, SCL is held low again if the host has not yet queued the next one. The host sees sticky status flags: buffer empty, byte end, NACK, START and STOP. It also sees a busy level and the direction of the last matching address. The sticky flags other than buffer empty are cleared by individual strobes.

Top module: `i2c_tgt_tx`

## Requirements
- R1: After reset every flag, busy and the direction bit read 0, and neither SCL nor SDA is driven.
- R2: An SDA fall while SCL is high (START) sets busy and the START flag. A repeated START while busy sets the START flag again, and busy stays 1.
- R3: The address byte is received MSB first: 7 address bits, then R/W. On a match with R/W=1, the direction bit becomes 1 and buffer empty is set. SCL is then held low in the ACK slot, with SDA released, for as long as the host has not written.
- R4: A host write during that hold causes the address to be acknowledged (SDA low for the ACK clock). The byte moves into the shift register and buffer empty reads 1 again.
- R5: Data bytes appear on SDA MSB first, and SDA driven by the block changes only while SCL is low.
- R6: A byte written while another byte is shifting waits in the transmit register. Buffer empty reads 0 until a master ACK moves the byte into the shifter. The next byte then follows without SCL being held.
- R7: A master ACK (SDA low in the ninth clock) sets the byte-end flag.
- R8: After a master ACK with no byte queued, SCL is held low until the host writes. That byte is then sent.
- R9: A master NACK sets the NACK flag. SDA and SCL are released, and further clocks read 1.
- R10: A STOP (SDA rise while SCL high) with busy set clears busy and sets the STOP flag.
- R11: A non-matching address is neither acknowledged nor stretched. A matching address with R/W=0 sets the direction bit to 0 and is not acknowledged.
- R12: Clear strobe bit [0] clears byte end, [1] clears NACK, [2] clears START and [3] clears STOP. Each strobe clears only its own flag. Otherwise flags hold, and a set in the same cycle wins over a clear. Buffer empty is cleared only by a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_oe_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | ADDR_W | Own 7-bit target address |
| txd_wr_i | input | 1 | Host write strobe for the transmit register |
| txd_i | input | ADDR_W+1 | Host transmit byte |
| clr_i | input | 4 | Flag clear strobes, positions per R12 |
| tbe_o | output | 1 | Transmit buffer empty |
| byte_end_o | output | 1 | Byte acknowledged by master |
| nack_o | output | 1 | NACK received |
| start_o | output | 1 | START or repeated START seen |
| stop_o | output | 1 | STOP seen while busy |
| busy_o | output | 1 | Bus transfer in progress |
| dir_o | output | 1 | R/W bit of the last matching address |

## Verification
The read path is tried with four host timings. In the first, the host writes only once the address hold has started, which separates a withheld ACK from an early one. In the second, the host writes during a byte shift, which shows that a queued byte waits and then follows without a stall. In the third, the host writes only after an ACK, which exposes the per-byte stretch. In the fourth, the master ends with a NACK, which shows the bus being released. Addresses that mismatch or carry a write bit show that nothing is acknowledged or stretched. A NACK followed by a repeated START and a second read shows that the engine restarts cleanly while busy stays set.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_HOLD_A, ST_ACK_A, ST_TX, ST_ACK_W, ST_HOLD_D, ST_DONE
  } tx_state_e;

  localparam int unsigned FLG_TBE   = 0;
  localparam int unsigned FLG_BEND  = 1;
  localparam int unsigned FLG_NACK  = 2;
  localparam int unsigned FLG_START = 3;
  localparam int unsigned FLG_STOP  = 4;
  localparam int unsigned NUM_FLG   = 5;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, lvl, prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b11;
    else         prev_q <= lvl;
  end

  assign scl_o      = lvl[0];
  assign sda_o      = lvl[1];
  assign scl_rise_o = lvl[0] & ~prev_q[0];
  assign scl_fall_o = ~lvl[0] & prev_q[0];
  // SDA edge with SCL high on both samples
  assign start_o    = lvl[0] & prev_q[0] & prev_q[1] & ~lvl[1];
  assign stop_o     = lvl[0] & prev_q[0] & ~prev_q[1] & lvl[1];
endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end

    // R12
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[g] && !clr_i[g]) |=> q_o[g]);
  end
endmodule

// File: rtl/i2c_tgt_tx.sv
module i2c_tgt_tx
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DATA_W     = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              txd_wr_i,
  input  logic [DATA_W-1:0] txd_i,
  input  logic [3:0]        clr_i,
  output logic              tbe_o,
  output logic              byte_end_o,
  output logic              nack_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              busy_o,
  output logic              dir_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .sda_o(sda_s), .start_o(start_det), .stop_o(stop_det)
  );

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, txd_q, txd_d;
  logic              full_q, full_d, ack_q, ack_d, busy_q, busy_d, dir_q, dir_d;
  logic [NUM_FLG-1:0] flg_set, flg_clr, flg_q;
  logic              load_ok;

  assign load_ok = full_q & ~txd_wr_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    txd_d   = txd_q;
    full_d  = full_q;
    ack_d   = ack_q;
    busy_d  = busy_q;
    dir_d   = dir_q;
    flg_set = '0;

    if (stop_det) begin
      flg_set[FLG_STOP] = busy_q;
      busy_d  = 1'b0;
      state_d = ST_IDLE;
    end else if (start_det) begin
      flg_set[FLG_START] = 1'b1;
      busy_d  = 1'b1;
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != CNT_W'(DATA_W)) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == CNT_W'(DATA_W)) begin
            state_d = ST_IDLE;
            if (sh_q[DATA_W-1:1] == own_addr_i) begin
              dir_d = sh_q[0];
              if (sh_q[0]) begin
                flg_set[FLG_TBE] = 1'b1;
                full_d  = 1'b0;       // stale byte discarded
                state_d = ST_HOLD_A;
              end
            end
          end
        end
        ST_HOLD_A: if (load_ok) begin
          sh_d    = txd_q;
          full_d  = 1'b0;
          flg_set[FLG_TBE] = 1'b1;
          state_d = ST_ACK_A;
        end
        ST_ACK_A: if (scl_fall) begin
          state_d = ST_TX;
          cnt_d   = '0;
        end
        ST_TX: if (scl_fall) begin
          if (cnt_q == CNT_W'(DATA_W - 1)) state_d = ST_ACK_W;
          else begin
            sh_d  = {sh_q[DATA_W-2:0], 1'b1};
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_ACK_W: begin
          if (scl_rise) ack_d = ~sda_s;
          if (scl_fall) begin
            if (!ack_q) begin
              flg_set[FLG_NACK] = 1'b1;
              state_d = ST_DONE;
            end else begin
              flg_set[FLG_BEND] = 1'b1;
              if (load_ok) begin
                sh_d    = txd_q;
                full_d  = 1'b0;
                flg_set[FLG_TBE] = 1'b1;
                state_d = ST_TX;
                cnt_d   = '0;
              end else state_d = ST_HOLD_D;
            end
          end
        end
        ST_HOLD_D: if (load_ok) begin
          sh_d    = txd_q;
          full_d  = 1'b0;
          flg_set[FLG_TBE] = 1'b1;
          state_d = ST_TX;
          cnt_d   = '0;
        end
        default: ;
      endcase
    end

    if (txd_wr_i) begin
      txd_d  = txd_i;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '1;
      txd_q   <= '0;
      full_q  <= 1'b0;
      ack_q   <= 1'b0;
      busy_q  <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      txd_q   <= txd_d;
      full_q  <= full_d;
      ack_q   <= ack_d;
      busy_q  <= busy_d;
      dir_q   <= dir_d;
    end
  end

  assign flg_clr = {clr_i[3], clr_i[2], clr_i[1], clr_i[0], txd_wr_i};

  i2c_tgt_flags #(.N(NUM_FLG)) flags_i (
    .clk_i, .rst_ni, .set_i(flg_set), .clr_i(flg_clr), .q_o(flg_q)
  );

  assign scl_oe_o   = (state_q == ST_HOLD_A) || (state_q == ST_HOLD_D);
  assign sda_oe_o   = (state_q == ST_ACK_A) || ((state_q == ST_TX) && !sh_q[DATA_W-1]);
  assign tbe_o      = flg_q[FLG_TBE];
  assign byte_end_o = flg_q[FLG_BEND];
  assign nack_o     = flg_q[FLG_NACK];
  assign start_o    = flg_q[FLG_START];
  assign stop_o     = flg_q[FLG_STOP];
  assign busy_o     = busy_q;
  assign dir_o      = dir_q;

  // R5
  sda_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

  // R3
  stretch_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> busy_o);

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> busy_o);

  // R10
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> !busy_o);

  // R9
  nack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nack_o) |-> (!sda_oe_o && !scl_oe_o));
endmodule

// File: tb/i2c_tgt_tx_tb_top.sv
`timescale 1ns/1ps
module i2c_tgt_tx_tb_top;
  localparam logic [6:0] OWN = 7'h52;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       txd_wr = 1'b0;
  logic [7:0] txd = '0;
  logic [3:0] clr = '0;
  logic       scl_oe, sda_oe, tbe, bend, nack, start, stop, busy, dir;
  logic       scl_bus, sda_bus;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_tgt_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(OWN),
    .txd_wr_i(txd_wr), .txd_i(txd), .clr_i(clr),
    .tbe_o(tbe), .byte_end_o(bend), .nack_o(nack), .start_o(start),
    .stop_o(stop), .busy_o(busy), .dir_o(dir)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tq();
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; scl_m = 1'b1; tq();
    sda_m = 1'b0; tq();
    scl_m = 1'b0; tq();
  endtask

  task automatic m_rstart();
    sda_m = 1'b1; tq();
    scl_m = 1'b1; wait_scl_high(); tq();
    sda_m = 1'b0; tq();
    scl_m = 1'b0; tq();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tq();
    scl_m = 1'b1; wait_scl_high(); tq();
    sda_m = 1'b1; tq();
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; tq();
    scl_m = 1'b1; wait_scl_high(); tq(); tq();
    scl_m = 1'b0; tq();
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; tq();
    scl_m = 1'b1; wait_scl_high(); tq();
    b = sda_bus; tq();
    scl_m = 1'b0; tq();
  endtask

  task automatic m_addr(input logic [6:0] a, input logic rw, output logic ack);
    logic [7:0] by;
    logic b;
    by = {a, rw};
    for (int i = 7; i >= 0; i--) m_wbit(by[i]);
    m_rbit(b);
    ack = ~b;
  endtask

  task automatic m_rbyte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b);
      d[i] = b;
    end
    m_wbit(~ack);
  endtask

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk); txd_wr = 1'b1; txd = d;
    @(negedge clk); txd_wr = 1'b0;
  endtask

  task automatic pulse_clr(input logic [3:0] m);
    @(negedge clk); clr = m;
    @(negedge clk); clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 tbe", tbe, 0);
    chk("R1 flags", {bend, nack, start, stop}, 0);
    chk("R1 busy/dir", {busy, dir}, 0);
    chk("R1 drives", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_addr_stretch();
    logic ack;
    m_start();
    chk("R2 start/busy", {start, busy}, 2'b11);
    fork
      m_addr(OWN, 1'b1, ack);
      begin
        while (!scl_oe) @(negedge clk);
        repeat (40) @(negedge clk);
        chk("R3 scl held", {scl_oe, scl_bus}, 2'b10);
        chk("R3 no ack yet", sda_oe, 0);
        chk("R3 tbe/dir", {tbe, dir}, 2'b11);
        host_wr(8'hA5);
        repeat (3) @(negedge clk);
        chk("R4 tbe after move", tbe, 1);
      end
    join
    chk("R4 address acked", ack, 1);
  endtask

  task automatic t_back_to_back();
    logic [7:0] d;
    fork
      m_rbyte(d, 1'b1);
      begin
        repeat (20) @(negedge clk);
        host_wr(8'h3C);
        chk("R6 tbe while queued", tbe, 0);
      end
    join
    chk("R5 byte 1 data", d, 8'hA5);
    chk("R7 byte end on ack", bend, 1);
    chk("R6 queued byte moved", tbe, 1);
    chk("R6 no stretch", scl_oe, 0);
    pulse_clr(4'b0001);
    chk("R12 byte end cleared", bend, 0);
    chk("R12 start untouched", start, 1);
  endtask

  task automatic t_data_stretch();
    logic [7:0] d;
    m_rbyte(d, 1'b1);
    chk("R6 byte 2 data", d, 8'h3C);
    chk("R8 stretch after ack", scl_oe, 1);
    chk("R7 byte end again", bend, 1);
    fork
      m_rbyte(d, 1'b0);
      begin
        repeat (40) @(negedge clk);
        chk("R8 scl still low", scl_bus, 0);
        host_wr(8'h81);
      end
    join
    chk("R8 byte 3 data", d, 8'h81);
  endtask

  task automatic t_nack_stop();
    logic b;
    chk("R9 nack flag", nack, 1);
    chk("R9 released", {sda_oe, scl_oe}, 0);
    m_rbit(b);
    chk("R9 no data after nack", b, 1);
    m_stop();
    chk("R10 stop/busy", {stop, busy}, 2'b10);
    pulse_clr(4'b1111);
    chk("R12 all cleared", {bend, nack, start, stop}, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    m_start();
    m_addr(OWN ^ 7'h01, 1'b1, ack);
    chk("R11 mismatch nacked", ack, 0);
    chk("R11 mismatch no stretch", scl_oe, 0);
    chk("R11 dir kept", dir, 1);
    m_stop();
    m_start();
    m_addr(OWN, 1'b0, ack);
    chk("R11 write nacked", ack, 0);
    chk("R11 dir write", dir, 0);
    m_stop();
    pulse_clr(4'b1111);
  endtask

  task automatic t_rstart();
    logic ack;
    logic [7:0] d;
    m_start();
    fork
      m_addr(OWN, 1'b1, ack);
      begin
        while (!scl_oe) @(negedge clk);
        host_wr(8'h5A);
      end
    join
    m_rbyte(d, 1'b0);
    chk("R5 first session data", d, 8'h5A);
    pulse_clr(4'b0100);
    chk("R12 start cleared", start, 0);
    chk("R12 nack kept", nack, 1);
    m_rstart();
    chk("R2 rstart flags", {start, busy}, 2'b11);
    fork
      m_addr(OWN, 1'b1, ack);
      begin
        while (!scl_oe) @(negedge clk);
        host_wr(8'hC3);
      end
    join
    chk("R4 rstart acked", ack, 1);
    m_rbyte(d, 1'b0);
    chk("R5 second session data", d, 8'hC3);
    m_stop();
    chk("R10 final stop", {stop, busy}, 2'b10);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_stretch();
    t_back_to_back();
    t_data_stretch();
    t_nack_stop();
    t_mismatch();
    t_rstart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule